// File: doc/BRIEF.md
# Stacked-Layer Coincidence Matcher

This block sits on one column of a two-layer tracking module. Each bunch crossing it receives a compact cluster word for its own column and for the two neighbouring columns, plus one cluster word from the paired sensor layer. It turns each word into a channel position and compares the paired position, after a signed correction for the shift between layers, with the three local positions. When one of them lies within one channel of the other, the block reports the matching local pattern together with its column and group address. A narrow positional agreement between the two layers marks a high-momentum track candidate. Without such agreement the result fields stay at zero.

One design serves both layers. A mode input selects the role. In the upper role the block matches, and it passes its own column word to its neighbours. In the lower role matching is switched off, and the block only forwards its own column word to the paired layer.

Top module: `stack_match`

## Requirements
- R1: While `rst_i` is high, and on the first clock edge after it, every output is zero.
- R2: A cluster word has three fields. Bits [3:0] hold the hit pattern, bits [8:4] hold the group number and bit 9 is a reject flag. The channel position is group×4 plus the index of the lowest set pattern bit, so a pattern 1100 in group 5 sits at position 22.
- R3: In upper mode, when `cross_vld_i` and `pair_vld_i` are both high, a stored word matches if its position minus (the paired position + `offset_i`) is -1, 0 or +1. The result registers on that clock edge, and `hit_o` is high after it. A cycle in which either valid is low yields no hit.
- R4: A position difference of 2 or more in either direction gives no hit.
- R5: A word whose reject flag is set, or whose pattern is 0000, never takes part in a match. This applies on either side.
- R6: The stored words are numbered 0 for the own column, 1 for the left neighbour and 2 for the right neighbour. When several of them match, the lowest number wins. `hit_col_o` reports that number, and `hit_grp_o`/`hit_pat_o` carry the group and pattern of the winning word.
- R7: `offset_i` is a two's-complement value that is added to the paired position before the comparison. A sum below zero is handled correctly.
- R8: In lower mode (`lower_mode_i`=1) `hit_o` is never set. One clock after `cross_vld_i`, `pair_out_vld_o` is high and `pair_out_word_o` equals the own column word. `nbr_vld_o` stays low.
- R9: In upper mode, one clock after `cross_vld_i`, `nbr_vld_o` is high and `nbr_word_o` equals the own column word. `pair_out_vld_o` stays low and `pair_out_word_o` stays zero.
- R10: Whenever `hit_o` is low, `hit_col_o`, `hit_grp_o` and `hit_pat_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| lower_mode_i | input | 1 | 1 selects the lower (forward-only) role |
| offset_i | input | OFS_W (4) | Signed correction added to the paired position |
| cross_vld_i | input | 1 | Own and neighbour words are valid this cycle |
| own_word_i | input | 10 | Own column cluster word |
| left_word_i | input | 10 | Left neighbour cluster word |
| right_word_i | input | 10 | Right neighbour cluster word |
| pair_vld_i | input | 1 | Paired-layer word is valid this cycle |
| pair_word_i | input | 10 | Cluster word from the paired layer |
| hit_o | output | 1 | Coincidence found |
| hit_col_o | output | 2 | Stored word that matched (0 own, 1 left, 2 right) |
| hit_grp_o | output | 5 | Group of the matched word |
| hit_pat_o | output | 4 | Pattern of the matched word |
| nbr_vld_o | output | 1 | Own word forwarded to the neighbours is valid |
| nbr_word_o | output | 10 | Own word for the neighbours |
| pair_out_vld_o | output | 1 | Own word forwarded to the paired layer is valid |
| pair_out_word_o | output | 10 | Own word for the paired layer |

## Verification
The hardest situation to reach is the one where more than one stored word qualifies at once, or where the corrected paired position falls below zero or crosses a group boundary. Random traffic at low occupancy almost never produces these cases. The vector table therefore builds them on purpose. Some vectors place the neighbour words one channel on either side of the paired position. Others place the own word out of range so that a lower-priority column wins. Negative offsets are combined with position 0, and words are placed at the last channel of a group.

// File: rtl/stack_match_pkg.sv
package stack_match_pkg;
  localparam int PAT_W  = 4;
  localparam int GRP_W  = 5;
  localparam int WORD_W = PAT_W + GRP_W + 1;
  localparam int IDX_W  = $clog2(PAT_W);
  localparam int POS_W  = GRP_W + IDX_W;
  localparam int ADJ_W  = POS_W + 2;
  localparam int NCOL   = 3;
  localparam int COL_W  = $clog2(NCOL);

  typedef logic [WORD_W-1:0] word_t;

  // group*PAT_W + lowest set bit; PAT_W is a power of two, so concatenation works
  function automatic logic [POS_W-1:0] word_pos(word_t w);
    logic [IDX_W-1:0] idx;
    idx = '0;
    for (int i = PAT_W - 1; i >= 0; i--)
      if (w[i]) idx = IDX_W'(i);
    return {w[PAT_W +: GRP_W], idx};
  endfunction

  function automatic logic word_ok(word_t w);
    return !w[WORD_W-1] && (|w[PAT_W-1:0]);
  endfunction
endpackage

// File: rtl/stack_match_lane.sv
module stack_match_lane
  import stack_match_pkg::*;
(
  input  word_t                   word_i,
  input  logic signed [ADJ_W-1:0] ref_pos_i,
  input  logic                    ref_ok_i,
  output logic                    hit_o
);
  logic signed [ADJ_W:0] own_pos;
  logic signed [ADJ_W:0] ref_ext;
  logic signed [ADJ_W:0] diff;

  assign own_pos = {3'b000, word_pos(word_i)};
  assign ref_ext = {ref_pos_i[ADJ_W-1], ref_pos_i};
  assign diff    = own_pos - ref_ext;

  // three-channel window: difference of -1, 0 or +1
  assign hit_o = ref_ok_i && word_ok(word_i) &&
                 ((diff == '0) || (diff == {(ADJ_W+1){1'b1}}) ||
                  (diff == (ADJ_W+1)'(1)));
endmodule

// File: rtl/stack_match_pick.sv
module stack_match_pick
  import stack_match_pkg::*;
(
  input  logic [NCOL-1:0] hits_i,
  input  word_t           words_i [NCOL],
  output logic            any_o,
  output logic [COL_W-1:0] col_o,
  output word_t           word_o
);
  always_comb begin
    any_o  = 1'b0;
    col_o  = '0;
    word_o = '0;
    for (int i = NCOL - 1; i >= 0; i--) begin
      if (hits_i[i]) begin
        any_o  = 1'b1;
        col_o  = COL_W'(i);
        word_o = words_i[i];
      end
    end
  end
endmodule

// File: rtl/stack_match.sv
module stack_match
  import stack_match_pkg::*;
#(
  parameter int OFS_W = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_i,
  input  logic                    lower_mode_i,
  input  logic signed [OFS_W-1:0] offset_i,
  input  logic                    cross_vld_i,
  input  logic [WORD_W-1:0]       own_word_i,
  input  logic [WORD_W-1:0]       left_word_i,
  input  logic [WORD_W-1:0]       right_word_i,
  input  logic                    pair_vld_i,
  input  logic [WORD_W-1:0]       pair_word_i,
  output logic                    hit_o,
  output logic [COL_W-1:0]        hit_col_o,
  output logic [GRP_W-1:0]        hit_grp_o,
  output logic [PAT_W-1:0]        hit_pat_o,
  output logic                    nbr_vld_o,
  output logic [WORD_W-1:0]       nbr_word_o,
  output logic                    pair_out_vld_o,
  output logic [WORD_W-1:0]       pair_out_word_o
);
  word_t                   stored [NCOL];
  logic signed [ADJ_W-1:0] ref_pos;
  logic signed [ADJ_W-1:0] ofs_ext;
  logic                    ref_ok;
  logic [NCOL-1:0]         lane_hit;
  logic                    any_hit;
  logic [COL_W-1:0]        pick_col;
  word_t                   pick_word;

  assign stored[0] = own_word_i;
  assign stored[1] = left_word_i;
  assign stored[2] = right_word_i;

  // offset correction only applies to the matching (upper) role
  assign ofs_ext = lower_mode_i ? '0 : {{(ADJ_W-OFS_W){offset_i[OFS_W-1]}}, offset_i};
  assign ref_pos = $signed({2'b00, word_pos(pair_word_i)}) + ofs_ext;
  assign ref_ok  = cross_vld_i && pair_vld_i && !lower_mode_i && word_ok(pair_word_i);

  for (genvar g = 0; g < NCOL; g++) begin : g_lane
    stack_match_lane lane_i (
      .word_i    (stored[g]),
      .ref_pos_i (ref_pos),
      .ref_ok_i  (ref_ok),
      .hit_o     (lane_hit[g])
    );
  end

  stack_match_pick pick_i (
    .hits_i  (lane_hit),
    .words_i (stored),
    .any_o   (any_hit),
    .col_o   (pick_col),
    .word_o  (pick_word)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      hit_o           <= 1'b0;
      hit_col_o       <= '0;
      hit_grp_o       <= '0;
      hit_pat_o       <= '0;
      nbr_vld_o       <= 1'b0;
      nbr_word_o      <= '0;
      pair_out_vld_o  <= 1'b0;
      pair_out_word_o <= '0;
    end else begin
      hit_o           <= any_hit;
      hit_col_o       <= pick_col;
      hit_grp_o       <= pick_word[PAT_W +: GRP_W];
      hit_pat_o       <= pick_word[PAT_W-1:0];
      nbr_vld_o       <= cross_vld_i && !lower_mode_i;
      nbr_word_o      <= (cross_vld_i && !lower_mode_i) ? own_word_i : '0;
      pair_out_vld_o  <= cross_vld_i && lower_mode_i;
      pair_out_word_o <= (cross_vld_i && lower_mode_i) ? own_word_i : '0;
    end
  end

  a_r3_hit_needs_both: assert property (@(posedge clk_i) disable iff (rst_i)
    hit_o |-> $past(cross_vld_i && pair_vld_i));
  a_r8_lower_no_hit: assert property (@(posedge clk_i) disable iff (rst_i)
    hit_o |-> !$past(lower_mode_i));
  a_r10_idle_zero: assert property (@(posedge clk_i) disable iff (rst_i)
    !hit_o |-> (hit_col_o == '0 && hit_grp_o == '0 && hit_pat_o == '0));
  a_r5_hit_pattern_set: assert property (@(posedge clk_i) disable iff (rst_i)
    hit_o |-> (hit_pat_o != '0));
  a_r6_col_range: assert property (@(posedge clk_i) disable iff (rst_i)
    hit_col_o < COL_W'(NCOL));
  a_r9_one_forward_path: assert property (@(posedge clk_i) disable iff (rst_i)
    !(nbr_vld_o && pair_out_vld_o));
endmodule

// File: tb/stack_match_tb_top.sv
module stack_match_tb_top;
  localparam int NV = 18;

  typedef struct packed {
    logic       mode;
    logic [3:0] off;
    logic [9:0] own;
    logic [9:0] left;
    logic [9:0] right;
    logic [9:0] pair;
    logic       ehit;
    logic [1:0] ecol;
    logic [4:0] egrp;
    logic [3:0] epat;
  } vec_t;

  function automatic logic [9:0] mk(logic f, logic [4:0] g, logic [3:0] p);
    return {f, g, p};
  endfunction

  localparam logic [9:0] Z = 10'h000;

  localparam vec_t VEC [NV] = '{
    '{1'b0, 4'h0, mk(0,5,1),  Z, Z, mk(0,5,1), 1'b1, 2'd0, 5'd5, 4'h1},  // R3 exact
    '{1'b0, 4'h0, mk(0,5,1),  Z, Z, mk(0,5,2), 1'b1, 2'd0, 5'd5, 4'h1},  // R3 diff -1
    '{1'b0, 4'h0, mk(0,5,4),  Z, Z, mk(0,5,1), 1'b0, 2'd0, 5'd0, 4'h0},  // R4 diff +2
    '{1'b0, 4'h0, mk(0,5,1),  Z, Z, mk(0,5,8), 1'b0, 2'd0, 5'd0, 4'h0},  // R4 diff -3
    '{1'b0, 4'h2, mk(0,5,4),  Z, Z, mk(0,5,1), 1'b1, 2'd0, 5'd5, 4'h4},  // R7 +2
    '{1'b0, 4'hD, mk(0,5,1),  Z, Z, mk(0,5,8), 1'b1, 2'd0, 5'd5, 4'h1},  // R7 -3
    '{1'b0, 4'hF, mk(0,0,1),  Z, Z, mk(0,0,1), 1'b1, 2'd0, 5'd0, 4'h1},  // R7 below zero
    '{1'b0, 4'h0, mk(1,5,1),  Z, Z, mk(0,5,1), 1'b0, 2'd0, 5'd0, 4'h0},  // R5 own rejected
    '{1'b0, 4'h0, mk(0,5,1),  Z, Z, mk(1,5,1), 1'b0, 2'd0, 5'd0, 4'h0},  // R5 pair rejected
    '{1'b0, 4'h0, mk(0,5,0),  mk(0,5,1), Z, mk(0,5,1), 1'b1, 2'd1, 5'd5, 4'h1}, // R5 empty own
    '{1'b0, 4'h0, mk(0,5,1),  mk(0,5,2), mk(0,4,8), mk(0,5,1), 1'b1, 2'd0, 5'd5, 4'h1}, // R6
    '{1'b0, 4'h0, mk(0,0,1),  mk(0,5,2), mk(0,5,1), mk(0,5,1), 1'b1, 2'd1, 5'd5, 4'h2}, // R6
    '{1'b0, 4'h0, mk(0,0,1),  mk(0,9,1), mk(0,5,1), mk(0,5,1), 1'b1, 2'd2, 5'd5, 4'h1}, // R6
    '{1'b0, 4'h0, mk(0,5,12), Z, Z, mk(0,5,8), 1'b1, 2'd0, 5'd5, 4'hC},  // R2 multi-bit
    '{1'b0, 4'h0, mk(0,31,8), Z, Z, mk(0,31,8), 1'b1, 2'd0, 5'd31, 4'h8}, // R2 last channel
    '{1'b0, 4'h0, mk(0,6,1),  Z, Z, mk(0,5,8), 1'b1, 2'd0, 5'd6, 4'h1},  // R2 across groups
    '{1'b1, 4'h0, mk(0,5,1),  Z, Z, mk(0,5,1), 1'b0, 2'd0, 5'd0, 4'h0},  // R8 lower
    '{1'b1, 4'h2, mk(0,5,4),  Z, Z, mk(0,5,1), 1'b0, 2'd0, 5'd0, 4'h0}   // R8 lower+offset
  };

  logic       clk_i = 1'b0;
  logic       rst_i;
  logic       lower_mode_i;
  logic [3:0] offset_i;
  logic       cross_vld_i, pair_vld_i;
  logic [9:0] own_word_i, left_word_i, right_word_i, pair_word_i;
  logic       hit_o, nbr_vld_o, pair_out_vld_o;
  logic [1:0] hit_col_o;
  logic [4:0] hit_grp_o;
  logic [3:0] hit_pat_o;
  logic [9:0] nbr_word_o, pair_out_word_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk_i = ~clk_i;

  stack_match dut_i (
    .clk_i, .rst_i, .lower_mode_i, .offset_i, .cross_vld_i,
    .own_word_i, .left_word_i, .right_word_i, .pair_vld_i, .pair_word_i,
    .hit_o, .hit_col_o, .hit_grp_o, .hit_pat_o,
    .nbr_vld_o, .nbr_word_o, .pair_out_vld_o, .pair_out_word_o
  );

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] res();
    return {11'd0, hit_o, hit_col_o, hit_grp_o, hit_pat_o, nbr_vld_o, pair_out_vld_o, 6'd0};
  endfunction

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst_i = 1'b1; lower_mode_i = 1'b0; offset_i = '0;
    cross_vld_i = 1'b1; pair_vld_i = 1'b1;
    own_word_i = mk(0,5,1); left_word_i = Z; right_word_i = Z; pair_word_i = mk(0,5,1);
    @(negedge clk_i);
    step();
    // R1 reset state, with matching inputs present
    chk(res() == 32'd0 && nbr_word_o == Z && pair_out_word_o == Z, "R1 reset", res(), 0);
    rst_i = 1'b0;

    for (int i = 0; i < NV; i++) begin
      lower_mode_i = VEC[i].mode; offset_i = VEC[i].off;
      own_word_i = VEC[i].own; left_word_i = VEC[i].left;
      right_word_i = VEC[i].right; pair_word_i = VEC[i].pair;
      cross_vld_i = 1'b1; pair_vld_i = 1'b1;
      step();
      chk({hit_o, hit_col_o, hit_grp_o, hit_pat_o} ==
          {VEC[i].ehit, VEC[i].ecol, VEC[i].egrp, VEC[i].epat},
          $sformatf("R3/R6 vector %0d", i),
          {20'd0, hit_o, hit_col_o, hit_grp_o, hit_pat_o},
          {20'd0, VEC[i].ehit, VEC[i].ecol, VEC[i].egrp, VEC[i].epat});
      if (VEC[i].mode)  // R8 forwarding to the paired layer
        chk(pair_out_vld_o && pair_out_word_o == VEC[i].own && !nbr_vld_o,
            $sformatf("R8 vector %0d", i), {pair_out_vld_o, nbr_vld_o, pair_out_word_o},
            {2'b10, VEC[i].own});
      else              // R9 forwarding to the neighbours
        chk(nbr_vld_o && nbr_word_o == VEC[i].own && !pair_out_vld_o && pair_out_word_o == Z,
            $sformatf("R9 vector %0d", i), {nbr_vld_o, pair_out_vld_o, nbr_word_o},
            {2'b10, VEC[i].own});
    end

    // R3: paired word missing -> no hit, forwarding still present
    lower_mode_i = 1'b0; offset_i = '0;
    own_word_i = mk(0,5,1); pair_word_i = mk(0,5,1); left_word_i = Z; right_word_i = Z;
    pair_vld_i = 1'b0; cross_vld_i = 1'b1;
    step();
    chk(!hit_o && nbr_vld_o && nbr_word_o == mk(0,5,1), "R3 pair invalid", res(), 32'h80);
    // R10: nothing valid -> every field zero
    cross_vld_i = 1'b0; pair_vld_i = 1'b1;
    step();
    chk(res() == 32'd0 && nbr_word_o == Z, "R10 idle", res(), 0);
    // R3: a hit drops one clock after valid goes away
    cross_vld_i = 1'b1;
    step();
    chk(hit_o == 1'b1, "R3 rehit", res(), 32'h0);
    cross_vld_i = 1'b0;
    step();
    chk(hit_o == 1'b0 && hit_pat_o == 4'h0, "R10 hit drop", res(), 0);
    // R1: reset during a running hit clears the outputs
    cross_vld_i = 1'b1;
    step();
    rst_i = 1'b1;
    step();
    chk(res() == 32'd0 && nbr_word_o == Z, "R1 reset mid-run", res(), 0);
    rst_i = 1'b0;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule